// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block drives a two-wire I2C bus as master, one bus primitive per command. A controller picks a primitive (bus recovery, START, STOP, byte write with acknowledge capture, byte read with a chosen response bit), presents it with a valid strobe, and waits for the one-cycle completion pulse. Any sequencing of primitives into transactions belongs to the caller.

Both bus lines are open drain. The block pulls a line low by raising its output enable. A released line reads as high unless another device pulls it low. Every bit is timed in a fixed delay unit of `div_i + 1` clock cycles. SCL is held high for two units in each data, acknowledge and recovery bit.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both output enables are 0 (lines released), busy_o is 0 and done_o is 0.
- R2: A command is accepted only when cmd_valid_i is high, busy_o is low and cmd_i is one of the codes 1 = recover, 2 = start, 3 = stop, 4 = write, 5 = read. busy_o is high in the cycle after acceptance. Codes 0, 6 and 7 are ignored, and so is any strobe while busy_o is high. An ignored strobe changes neither the waveform nor the length of the primitive in progress.
- R3: One delay unit lasts div_i + 1 clock cycles. busy_o stays high for exactly N units, with N = 40 (recover), 3 (start), 4 (stop), 37 (write) or 29 (read). done_o is high for exactly the one cycle after busy_o falls.
- R4: Start uses one unit per step: release SDA, release SCL, then pull SDA low. SCL stays released during the last step.
- R5: Stop uses one unit per step: pull SCL low, pull SDA low, release SCL, then release SDA. It ends with both lines released.
- R6: A write sends wdata_i MSB first. Each bit lasts 4 units: SCL is pulled low, SDA takes the bit one unit later, and SCL is released for the last two units.
- R7: The ninth write bit releases SDA and releases SCL for two units. At the end of that high time, SDA is captured into nack_o (0 = acknowledged, 1 = not acknowledged). One final unit then holds SCL low, and the write ends with SCL low and SDA released.
- R8: A read releases SDA for 8 bits of 3 units each: SCL low for one unit, then released for two. SDA is sampled at the end of the first high unit. rdata_o holds the 8 samples MSB first when done_o rises.
- R9: After the 8 read bits, SCL is pulled low. One unit later SDA is pulled low when rd_nack_i (latched at acceptance) was 0, and left released when it was 1. SCL is then released for two units and pulled low for one. The read ends with SCL low and SDA released.
- R10: Recover keeps SDA released while giving 9 SCL pulses of two low units and two high units each. It then runs the four stop steps and ends with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Primitive code (1 recover, 2 start, 3 stop, 4 write, 5 read) |
| cmd_valid_i | input | 1 | Command strobe |
| wdata_i | input | 8 | Byte to send, latched at acceptance |
| rd_nack_i | input | 1 | Response after a read byte: 0 acknowledge, 1 not acknowledge |
| div_i | input | DIV_W | Delay unit length minus one, in clock cycles |
| busy_o | output | 1 | A primitive is in progress |
| done_o | output | 1 | One-cycle pulse when a primitive completes |
| rdata_o | output | 8 | Last byte read |
| nack_o | output | 1 | Acknowledge level captured by the last write |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |

## Verification
The bench builds the block with DIV_W = 3, so a single run reaches the whole range of unit lengths from 1 to 8 cycles. Divider values 0 and 7 are both checked directly. Per clock, the bench compares the line enables against a unit-by-unit waveform it builds itself. This exposes any off-by-one in where a unit ends. A responder in the bench pulls SDA per unit, which exercises both acknowledge levels and arbitrary read bytes.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RECOVER = 3'd1,
        OP_START   = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_READ    = 3'd5
    } op_e;

    localparam int GRP_W  = 4;
    localparam int SLOT_W = 3;

    typedef struct packed {
        logic              busy;
        op_e               op;
        logic [GRP_W-1:0]  grp;
        logic [SLOT_W-1:0] slot;
        logic              scl_lo;
        logic              sda_lo;
        logic [7:0]        shift;
        logic [7:0]        rdata;
        logic              nack;
        logic              resp;
        logic              done;
    } seq_st_t;

    // index of the final group of a primitive
    function automatic logic [GRP_W-1:0] final_grp(op_e op);
        case (op)
            OP_WRITE:   return 4'd9;
            OP_READ:    return 4'd8;
            OP_RECOVER: return 4'd9;
            default:    return 4'd0;
        endcase
    endfunction

    // index of the final slot (unit) inside a group
    function automatic logic [SLOT_W-1:0] final_slot(op_e op, logic [GRP_W-1:0] g);
        case (op)
            OP_START: return 3'd2;
            OP_WRITE: return (g == 4'd9) ? 3'd0 : 3'd3;
            OP_READ:  return (g == 4'd8) ? 3'd4 : 3'd2;
            default:  return 3'd3;
        endcase
    endfunction

    // line pull-down state on entry to a slot: {scl_lo, sda_lo}
    function automatic logic [1:0] slot_drive(op_e op, logic [GRP_W-1:0] g,
                                              logic [SLOT_W-1:0] s, logic wbit,
                                              logic resp, logic scl_c, logic sda_c);
        logic c;
        logic d;
        c = scl_c;
        d = sda_c;
        case (op)
            OP_START: begin
                if (s == 3'd0) d = 1'b0;
                else if (s == 3'd1) c = 1'b0;
                else d = 1'b1;
            end
            OP_STOP: begin
                case (s)
                    3'd0:    c = 1'b1;
                    3'd1:    d = 1'b1;
                    3'd2:    c = 1'b0;
                    default: d = 1'b0;
                endcase
            end
            OP_WRITE: begin
                if (g == 4'd9) c = 1'b1;
                else if (s == 3'd0) c = 1'b1;
                else if (s == 3'd1) d = (g == 4'd8) ? 1'b0 : ~wbit;
                else if (s == 3'd2) c = 1'b0;
            end
            OP_READ: begin
                if (g == 4'd8) begin
                    case (s)
                        3'd0:    c = 1'b1;
                        3'd1:    d = ~resp;
                        3'd2:    c = 1'b0;
                        3'd4:    c = 1'b1;
                        default: ;
                    endcase
                end else if (s == 3'd0) begin
                    c = 1'b1;
                    d = 1'b0;
                end else if (s == 3'd1) begin
                    c = 1'b0;
                end
            end
            OP_RECOVER: begin
                if (g == 4'd9) begin
                    case (s)
                        3'd0:    c = 1'b1;
                        3'd1:    d = 1'b1;
                        3'd2:    c = 1'b0;
                        default: d = 1'b0;
                    endcase
                end else if (s == 3'd0) begin
                    c = 1'b1;
                    d = 1'b0;
                end else if (s == 3'd2) begin
                    c = 1'b0;
                end
            end
            default: ;
        endcase
        return {c, d};
    endfunction

endpackage

// File: rtl/i2c_eng_tick.sv
module i2c_eng_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        cnt_d  = (!run_i || tick_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && $stable(div_i) |-> cnt_q <= div_i);  // R3

endmodule

// File: rtl/i2c_eng_seq.sv
module i2c_eng_seq
    import i2c_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd_i,
    input  logic       cmd_valid_i,
    input  logic [7:0] wdata_i,
    input  logic       rd_nack_i,
    input  logic       tick_i,
    input  logic       sda_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rdata_o,
    output logic       nack_o,
    output logic       scl_lo_o,
    output logic       sda_lo_o
);
    seq_st_t st_d, st_q;
    op_e     req_op;
    logic    req_ok;
    logic    wbit;
    logic [GRP_W-1:0]  g_nx;
    logic [SLOT_W-1:0] s_nx;
    logic [1:0]        drv;

    always_comb begin
        req_op = op_e'(cmd_i);
        req_ok = cmd_valid_i && !st_q.busy &&
                 (cmd_i >= 3'd1) && (cmd_i <= 3'd5);
        st_d   = st_q;
        st_d.done = 1'b0;
        g_nx   = st_q.grp;
        s_nx   = st_q.slot;
        wbit   = 1'b0;
        drv    = {st_q.scl_lo, st_q.sda_lo};

        if (req_ok) begin
            st_d.busy  = 1'b1;
            st_d.op    = req_op;
            st_d.grp   = '0;
            st_d.slot  = '0;
            st_d.shift = wdata_i;
            st_d.resp  = rd_nack_i;
            drv = slot_drive(req_op, '0, '0, wdata_i[7], rd_nack_i,
                             st_q.scl_lo, st_q.sda_lo);
            st_d.scl_lo = drv[1];
            st_d.sda_lo = drv[0];
        end else if (st_q.busy && tick_i) begin
            if (st_q.op == OP_WRITE && st_q.grp == 4'd8 && st_q.slot == 3'd3)
                st_d.nack = sda_i;
            if (st_q.op == OP_READ && st_q.grp < 4'd8 && st_q.slot == 3'd1)
                st_d.shift = {st_q.shift[6:0], sda_i};

            if (st_q.slot == final_slot(st_q.op, st_q.grp)) begin
                if (st_q.grp == final_grp(st_q.op)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    if (st_q.op == OP_READ) begin
                        st_d.sda_lo = 1'b0;
                        st_d.rdata  = st_q.shift;
                    end
                end else begin
                    g_nx = st_q.grp + 1'b1;
                    s_nx = '0;
                end
            end else begin
                s_nx = st_q.slot + 1'b1;
            end

            if (st_d.busy) begin
                wbit = (g_nx < 4'd8) ? st_q.shift[~g_nx[2:0]] : 1'b0;
                drv  = slot_drive(st_q.op, g_nx, s_nx, wbit, st_q.resp,
                                  st_q.scl_lo, st_q.sda_lo);
                st_d.grp    = g_nx;
                st_d.slot   = s_nx;
                st_d.scl_lo = drv[1];
                st_d.sda_lo = drv[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, op: OP_NONE, grp: '0, slot: '0,
                      scl_lo: 1'b0, sda_lo: 1'b0, shift: '0, rdata: '0,
                      nack: 1'b0, resp: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign rdata_o  = st_q.rdata;
    assign nack_o   = st_q.nack;
    assign scl_lo_o = st_q.scl_lo;
    assign sda_lo_o = st_q.sda_lo;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);  // R3
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> st_q.done);  // R3
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && cmd_valid_i |=> $stable(st_q.op));  // R2
    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && $past(st_q.busy) && (st_q.op == OP_WRITE || st_q.op == OP_READ)
        && !st_q.scl_lo && !$past(st_q.scl_lo) |-> $stable(st_q.sda_lo));  // R6
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && (st_q.op == OP_STOP || st_q.op == OP_RECOVER)
        |-> !st_q.scl_lo && !st_q.sda_lo);  // R5

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_i,
    input  logic             cmd_valid_i,
    input  logic [7:0]       wdata_i,
    input  logic             rd_nack_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [7:0]       rdata_o,
    output logic             nack_o,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    input  logic             scl_i,
    input  logic             sda_i
);
    logic tick;
    logic busy;
    logic scl_unused;

    assign scl_unused = scl_i;

    i2c_eng_tick #(.W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .div_i  (div_i),
        .tick_o (tick)
    );

    i2c_eng_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd_i),
        .cmd_valid_i (cmd_valid_i),
        .wdata_i     (wdata_i),
        .rd_nack_i   (rd_nack_i),
        .tick_i      (tick),
        .sda_i       (sda_i),
        .busy_o      (busy),
        .done_o      (done_o),
        .rdata_o     (rdata_o),
        .nack_o      (nack_o),
        .scl_lo_o    (scl_oe_o),
        .sda_lo_o    (sda_oe_o)
    );

    assign busy_o = busy;

endmodule

// File: tb/sim_i2c_bit_engine.sv
`timescale 1ns/1ps
module sim_i2c_bit_engine;
    localparam int DW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cmd_i = '0;
    logic cmd_valid_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic rd_nack_i = 1'b0;
    logic [DW-1:0] div_i = '0;
    logic busy_o, done_o, nack_o, scl_oe_o, sda_oe_o;
    logic [7:0] rdata_o;
    logic slave_lo = 1'b0;
    logic scl_i, sda_i;

    assign scl_i = ~scl_oe_o;
    assign sda_i = ~sda_oe_o & ~slave_lo;

    always #2 clk = ~clk;

    i2c_bit_engine #(.DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .cmd_valid_i(cmd_valid_i),
        .wdata_i(wdata_i), .rd_nack_i(rd_nack_i), .div_i(div_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .nack_o(nack_o),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .scl_i(scl_i), .sda_i(sda_i)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic exp_scl [0:63];
    logic exp_sda [0:63];
    int   nu;
    logic cur_scl = 1'b0;
    logic cur_sda = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic s, input logic d);
        exp_scl[nu] = s;
        exp_sda[nu] = d;
        cur_scl = s;
        cur_sda = d;
        nu++;
    endtask

    task automatic stop_wave();
        push(1'b1, cur_sda); push(1'b1, 1'b1); push(1'b0, 1'b1); push(1'b0, 1'b0);
    endtask

    // expected per-unit enables of the master, from the requirements
    task automatic build(input int cmd, input logic [7:0] w, input logic resp);
        nu = 0;
        case (cmd)
            1: begin
                for (int p = 0; p < 9; p++) begin
                    push(1'b1, 1'b0); push(1'b1, 1'b0); push(1'b0, 1'b0); push(1'b0, 1'b0);
                end
                stop_wave();
            end
            2: begin push(cur_scl, 1'b0); push(1'b0, 1'b0); push(1'b0, 1'b1); end
            3: stop_wave();
            4: begin
                for (int b = 7; b >= 0; b--) begin
                    push(1'b1, cur_sda); push(1'b1, ~w[b]); push(1'b0, cur_sda); push(1'b0, cur_sda);
                end
                push(1'b1, cur_sda); push(1'b1, 1'b0); push(1'b0, 1'b0); push(1'b0, 1'b0);
                push(1'b1, 1'b0);
            end
            default: begin
                for (int b = 0; b < 8; b++) begin
                    push(1'b1, 1'b0); push(1'b0, 1'b0); push(1'b0, 1'b0);
                end
                push(1'b1, 1'b0); push(1'b1, ~resp); push(1'b0, cur_sda); push(1'b0, cur_sda);
                push(1'b1, cur_sda);
                cur_sda = 1'b0;
            end
        endcase
    endtask

    function automatic int units_of(input int cmd);
        case (cmd)
            1: return 40;
            2: return 3;
            3: return 4;
            4: return 37;
            default: return 29;
        endcase
    endfunction

    task automatic run(input int cmd, input logic [7:0] w, input logic resp,
                       input int dv, input logic [7:0] sbyte, input logic ack_lo,
                       input bit inject);
        int len, c, u;
        bit wave_ok, busy_ok;
        int bad_c;
        build(cmd, w, resp);
        len = units_of(cmd) * (dv + 1);
        wave_ok = 1; busy_ok = 1; bad_c = -1;
        @(negedge clk);
        div_i = dv[DW-1:0];
        cmd_i = cmd[2:0]; wdata_i = w; rd_nack_i = resp; cmd_valid_i = 1'b1;
        for (c = 0; c < len; c++) begin
            @(negedge clk);
            u = c / (dv + 1);
            if (c == 0) cmd_valid_i = 1'b0;
            if (inject && c == 2) begin cmd_i = 3'd3; cmd_valid_i = 1'b1; end
            if (inject && c == 3) cmd_valid_i = 1'b0;
            if (!busy_o) busy_ok = 0;
            if (scl_oe_o !== exp_scl[u] || sda_oe_o !== exp_sda[u]) begin
                if (bad_c < 0) bad_c = c;
                wave_ok = 0;
            end
            if (cmd == 4) slave_lo = (u >= 32 && u <= 35) ? ack_lo : 1'b0;
            else if (cmd == 5) slave_lo = (u < 24) ? ~sbyte[7 - u / 3] : 1'b0;
            else slave_lo = 1'b0;
        end
        // R4 R5 R6 R9 R10: waveform per clock; R2 when injected
        chk(wave_ok, $sformatf("R6/R4/R5/R9/R10 wave cmd=%0d div=%0d inject=%0d first bad clk", cmd, dv, inject),
            bad_c, -1);
        chk(busy_ok, "R3 busy held for whole primitive", busy_ok, 1);
        @(negedge clk);
        slave_lo = 1'b0;
        chk(!busy_o && done_o, "R3 busy falls with done pulse", {busy_o, done_o}, 1);
        chk(scl_oe_o === cur_scl && sda_oe_o === cur_sda, "R7/R9/R5 end state of lines",
            {scl_oe_o, sda_oe_o}, {cur_scl, cur_sda});
        if (cmd == 4) chk(nack_o === ~ack_lo, "R7 acknowledge capture", nack_o, ~ack_lo);
        if (cmd == 5) chk(rdata_o === sbyte, "R8 read byte MSB first", rdata_o, sbyte);
        @(negedge clk);
        chk(!done_o, "R3 done lasts one cycle", done_o, 0);
    endtask

    task automatic bad_code(input logic [2:0] code);
        logic s0, d0;
        @(negedge clk);
        s0 = scl_oe_o; d0 = sda_oe_o;
        cmd_i = code; cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        chk(!busy_o, "R2 invalid code not accepted", busy_o, 0);
        @(negedge clk);
        chk(!busy_o && !done_o && scl_oe_o === s0 && sda_oe_o === d0,
            "R2 invalid code leaves lines", {busy_o, done_o, scl_oe_o, sda_oe_o}, {2'b00, s0, d0});
    endtask

    initial begin
        #800000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed, cmd, dv;
        logic [7:0] w, sb;
        logic rsp, al;
        seed = 32'h1c2b;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk(!scl_oe_o && !sda_oe_o && !busy_o && !done_o, "R1 reset state",
            {scl_oe_o, sda_oe_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !scl_oe_o && !sda_oe_o, "R1 idle after reset", busy_o, 0);

        run(1, 8'h00, 1'b0, 1, 8'h00, 1'b0, 0);      // R10
        run(2, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);      // R4
        run(4, 8'hA5, 1'b0, 2, 8'h00, 1'b1, 0);      // R6 R7 ack
        run(4, 8'h3C, 1'b0, 7, 8'h00, 1'b0, 0);      // R7 nack, div max
        run(5, 8'h00, 1'b0, 0, 8'h96, 1'b0, 0);      // R8 R9 ack
        run(5, 8'h00, 1'b1, 3, 8'hFF, 1'b0, 0);      // R9 nack
        run(4, 8'h81, 1'b0, 1, 8'h00, 1'b1, 1);      // R2 strobe while busy
        run(3, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);      // R5
        bad_code(3'd0);
        bad_code(3'd6);
        bad_code(3'd7);

        for (int k = 0; k < 30; k++) begin
            cmd = 1 + int'($urandom % 5);
            dv  = int'($urandom % 4);
            w   = 8'($urandom);
            sb  = 8'($urandom);
            rsp = 1'($urandom);
            al  = 1'($urandom);
            run(cmd, w, rsp, dv, sb, al, (k % 7) == 3);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule